// File: doc/BRIEF.md
# Byte-Counted Word FIFO Port

This block connects a host register bus that can only make full 32-bit accesses to a set of byte-wide endpoint FIFOs. Before moving data, software writes the number of bytes for the coming transfer into a size register belonging to the endpoint and direction. The host then moves only whole words through a data window. On the transmit side each written word is split into bytes, lowest lane first, and only as many bytes as the remaining count allows enter the endpoint's transmit FIFO. On the receive side each read pulls up to four bytes from the endpoint's receive FIFO and packs them into a word, with unused upper lanes returned as zero.

Endpoint 0 is the control endpoint. It has one combined configuration register holding a size and a direction flag, so only one direction is armed at a time. Every other endpoint has independent transmit and receive size registers. An access that finds nothing left to move, or a FIFO that cannot take or supply the bytes, is dropped and latches a per-endpoint error flag that stays set until software reprograms a size register of that endpoint. The serial side of each FIFO is a simple pop/push byte port.

Top module: `wfp_word_port`

## Requirements
- R1: After reset every remaining count is zero, every error flag is clear, every transmit FIFO reports empty, no receive FIFO reports full and `host_rvalid` is low.
- R2: The word address is {endpoint, window}: window 0 is the data window, window 1 the transmit size register (combined configuration register on endpoint 0), window 2 the receive size register, window 3 reads as zero. Reading a size register returns the bytes still to move in bits 15:0.
- R3: On endpoint 0, bit 16 of the configuration register selects the direction (1 transmit, 0 receive) and bits 15:0 the size; loading it arms only the chosen direction, reading it returns bit 16 as the direction, and a data access in the other direction is an error.
- R4: A data write while 4 or more bytes remain pushes all four lanes into the transmit FIFO in the order bits 7:0, 15:8, 23:16, 31:24 and lowers the remaining count by 4.
- R5: A data write while 1 to 3 bytes remain pushes only that many low lanes; the upper lanes never reach the FIFO and the count reaches zero.
- R6: A data read returns, one cycle after `host_rd`, with `host_rvalid` high, the next min(4, remaining) receive bytes, the earliest in bits 7:0, and lowers the count by that amount.
- R7: When fewer than 4 bytes remain, a read returns the valid bytes in the low lanes and zero in every unused upper lane.
- R8: A data access while the count for that direction is zero moves nothing, returns zero on a read and sets the endpoint's error flag.
- R9: A write when the transmit FIFO lacks room for the bytes it would push, or a read when the receive FIFO holds fewer bytes than it would pop, moves nothing, leaves the count unchanged, returns zero on a read and sets the error flag.
- R10: An error flag stays set until a write to a size register of its endpoint clears it.
- R11: The serial side pops transmit bytes in FIFO order per endpoint; a pop of an empty FIFO and a push into a full receive FIFO are ignored.
- R12: When `host_wr` and `host_rd` are high together, the write is performed and the read is not (no `host_rvalid`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host word write strobe |
| host_rd | input | 1 | Host word read strobe |
| host_addr | input | EP_W+2 | Word address {endpoint, window} |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after an accepted read |
| usb_tx_pop | input | 1 | Pop one byte from the selected transmit FIFO |
| usb_tx_ep | input | EP_W | Endpoint selected for popping |
| usb_tx_byte | output | 8 | Head byte of the selected transmit FIFO |
| usb_tx_empty | output | NUM_EP | Per-endpoint transmit FIFO empty |
| usb_rx_push | input | 1 | Push one byte into the selected receive FIFO |
| usb_rx_ep | input | EP_W | Endpoint selected for pushing |
| usb_rx_byte | input | 8 | Byte to push |
| usb_rx_full | output | NUM_EP | Per-endpoint receive FIFO full |
| ep_err | output | NUM_EP | Sticky per-endpoint access error |

## Verification
Transmit is tried with a count that is a multiple of four plus a remainder, so popped bytes show both lane order and the discarding of lanes past the count; receive is tried with seven bytes, which separates the full-word packing from the zero padding of the final word. Counts of zero, the wrong control-endpoint direction, a receive FIFO short of data and a transmit FIFO without room each separate "nothing moved and flag set" from a silent partial transfer, and reading the size registers back shows the count was left alone. A full receive FIFO followed by one extra push, then drained by reads, shows the extra byte was never stored, and a cycle with both strobes high shows the write landing while no read data appears.

// File: rtl/wfp_pkg.sv
package wfp_pkg;

    localparam int LANES = 4;

    typedef logic [LANES-1:0][7:0] word_lanes_t;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_TXSZ = 2'd1,
        SEL_RXSZ = 2'd2,
        SEL_RSVD = 2'd3
    } win_sel_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        win_sel_e sel;
    } host_op_t;

    // Number of byte lanes a single word access may move for a given remaining count.
    function automatic logic [2:0] lanes_for(input logic [31:0] rem);
        if (rem > 32'd3) return 3'd4;
        return rem[2:0];
    endfunction

    // Keep the lowest n lanes, zero the rest.
    function automatic word_lanes_t pad_word(input word_lanes_t w, input logic [2:0] n);
        word_lanes_t o;
        for (int k = 0; k < LANES; k++) o[k] = (k < int'(n)) ? w[k] : 8'h00;
        return o;
    endfunction

endpackage

// File: rtl/wfp_byte_fifo.sv
module wfp_byte_fifo #(
    parameter int DEPTH    = 16,
    parameter int WR_LANES = 4,
    parameter int RD_LANES = 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [2:0]               wr_n,
    input  logic [WR_LANES-1:0][7:0] wr_lanes,
    input  logic [2:0]               rd_n,
    output logic [RD_LANES-1:0][7:0] rd_lanes,
    output logic [$clog2(DEPTH):0]   level
);
    localparam int PW = $clog2(DEPTH);
    localparam int LW = PW + 1;

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wp;
    logic [PW-1:0] rp;

    always_ff @(posedge clk) begin
        for (int k = 0; k < WR_LANES; k++) begin
            if (k < int'(wr_n)) mem[wp + PW'(k)] <= wr_lanes[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            wp    <= wp + PW'(wr_n);
            rp    <= rp + PW'(rd_n);
            level <= level + LW'(wr_n) - LW'(rd_n);
        end
    end

    always_comb begin
        for (int k = 0; k < RD_LANES; k++) rd_lanes[k] = mem[rp + PW'(k)];
    end

    // The port logic must never push past the free space or pop past the fill.
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        int'(wr_n) <= DEPTH - int'(level));
    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
        int'(rd_n) <= int'(level));
    assert_level_bound_R11: assert property (@(posedge clk) disable iff (rst)
        int'(level) <= DEPTH);

endmodule

// File: rtl/wfp_ep_counter.sv
module wfp_ep_counter #(
    parameter int SIZE_W  = 16,
    parameter bit IS_CTRL = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_tx,
    input  logic              load_rx,
    input  logic [SIZE_W-1:0] load_val,
    input  logic              load_dir,
    input  logic [2:0]        take_tx,
    input  logic [2:0]        take_rx,
    input  logic              fault,
    output logic [SIZE_W-1:0] tx_rem,
    output logic [SIZE_W-1:0] rx_rem,
    output logic              dir,
    output logic              err
);
    logic cfg_hit;
    assign cfg_hit = load_tx || (load_rx && !IS_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_rem <= '0;
            rx_rem <= '0;
            dir    <= 1'b0;
            err    <= 1'b0;
        end else begin
            if (load_tx) begin
                dir <= IS_CTRL ? load_dir : 1'b0;
                if (IS_CTRL) begin
                    tx_rem <= load_dir ? load_val : '0;
                    rx_rem <= load_dir ? '0 : load_val;
                end else begin
                    tx_rem <= load_val;
                end
            end else if (load_rx && !IS_CTRL) begin
                rx_rem <= load_val;
            end else begin
                tx_rem <= tx_rem - SIZE_W'(take_tx);
                rx_rem <= rx_rem - SIZE_W'(take_rx);
            end
            if (cfg_hit)    err <= 1'b0;
            else if (fault) err <= 1'b1;
        end
    end

    assert_take_within_R5: assert property (@(posedge clk) disable iff (rst)
        (int'(take_tx) <= int'(tx_rem)) && (int'(take_rx) <= int'(rx_rem)));
    assert_rem_no_rise_R4: assert property (@(posedge clk) disable iff (rst)
        !cfg_hit |=> (tx_rem <= $past(tx_rem)) && (rx_rem <= $past(rx_rem)));
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (err && !cfg_hit) |=> err);

endmodule

// File: rtl/wfp_word_port.sv
module wfp_word_port
    import wfp_pkg::*;
#(
    parameter int NUM_EP     = 4,
    parameter int FIFO_DEPTH = 16,
    parameter int SIZE_W     = 16,
    localparam int EP_W      = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
    localparam int ADDR_W    = EP_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              host_rvalid,
    input  logic              usb_tx_pop,
    input  logic [EP_W-1:0]   usb_tx_ep,
    output logic [7:0]        usb_tx_byte,
    output logic [NUM_EP-1:0] usb_tx_empty,
    input  logic              usb_rx_push,
    input  logic [EP_W-1:0]   usb_rx_ep,
    input  logic [7:0]        usb_rx_byte,
    output logic [NUM_EP-1:0] usb_rx_full,
    output logic [NUM_EP-1:0] ep_err
);
    localparam int LW = $clog2(FIFO_DEPTH) + 1;

    host_op_t        op;
    logic [EP_W-1:0] acc_ep;
    logic            ep_ok;

    always_comb begin
        op.wr  = host_wr;
        op.rd  = host_rd && !host_wr;
        op.sel = win_sel_e'(host_addr[1:0]);
    end
    assign acc_ep = host_addr[ADDR_W-1:2];

    generate
        if ((1 << EP_W) == NUM_EP) begin : g_ep_full
            assign ep_ok = 1'b1;
        end else begin : g_ep_part
            assign ep_ok = int'(acc_ep) < NUM_EP;
        end
    endgenerate

    // Per-endpoint state
    logic [SIZE_W-1:0] tx_rem   [NUM_EP];
    logic [SIZE_W-1:0] rx_rem   [NUM_EP];
    logic              dir_vec  [NUM_EP];
    logic [LW-1:0]     tx_level [NUM_EP];
    logic [LW-1:0]     rx_level [NUM_EP];
    logic [7:0]        tx_head  [NUM_EP];
    word_lanes_t       rx_peek  [NUM_EP];
    logic [2:0]        tx_wr_n  [NUM_EP];
    logic [2:0]        tx_rd_n  [NUM_EP];
    logic [2:0]        rx_wr_n  [NUM_EP];
    logic [2:0]        rx_rd_n  [NUM_EP];

    // Access decision for the addressed endpoint
    logic [SIZE_W-1:0] sel_tx_rem;
    logic [SIZE_W-1:0] sel_rx_rem;
    logic [2:0]        n_tx;
    logic [2:0]        n_rx;
    logic              wr_data_hit;
    logic              rd_data_hit;
    logic              tx_go;
    logic              rx_go;
    logic              fault_hit;
    logic              is_ctrl_acc;

    always_comb begin
        sel_tx_rem  = tx_rem[acc_ep];
        sel_rx_rem  = rx_rem[acc_ep];
        n_tx        = lanes_for(32'(sel_tx_rem));
        n_rx        = lanes_for(32'(sel_rx_rem));
        is_ctrl_acc = (acc_ep == '0);
        wr_data_hit = op.wr && ep_ok && (op.sel == SEL_DATA);
        rd_data_hit = op.rd && ep_ok && (op.sel == SEL_DATA);
        tx_go       = wr_data_hit && (sel_tx_rem != '0) &&
                      ((int'(n_tx) + int'(tx_level[acc_ep])) <= FIFO_DEPTH);
        rx_go       = rd_data_hit && (sel_rx_rem != '0) &&
                      (int'(n_rx) <= int'(rx_level[acc_ep]));
        fault_hit   = (wr_data_hit && !tx_go) || (rd_data_hit && !rx_go);
    end

    generate
        for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
            logic hit;
            assign hit = ep_ok && (acc_ep == EP_W'(i));

            assign tx_wr_n[i] = (tx_go && hit) ? n_tx : 3'd0;
            assign tx_rd_n[i] = (usb_tx_pop && (usb_tx_ep == EP_W'(i)) && (tx_level[i] != '0))
                                ? 3'd1 : 3'd0;
            assign rx_wr_n[i] = (usb_rx_push && (usb_rx_ep == EP_W'(i)) &&
                                 (int'(rx_level[i]) < FIFO_DEPTH)) ? 3'd1 : 3'd0;
            assign rx_rd_n[i] = (rx_go && hit) ? n_rx : 3'd0;

            wfp_byte_fifo #(
                .DEPTH   (FIFO_DEPTH),
                .WR_LANES(LANES),
                .RD_LANES(1)
            ) u_tx_fifo (
                .clk     (clk),
                .rst     (rst),
                .wr_n    (tx_wr_n[i]),
                .wr_lanes(host_wdata),
                .rd_n    (tx_rd_n[i]),
                .rd_lanes(tx_head[i]),
                .level   (tx_level[i])
            );

            wfp_byte_fifo #(
                .DEPTH   (FIFO_DEPTH),
                .WR_LANES(1),
                .RD_LANES(LANES)
            ) u_rx_fifo (
                .clk     (clk),
                .rst     (rst),
                .wr_n    (rx_wr_n[i]),
                .wr_lanes(usb_rx_byte),
                .rd_n    (rx_rd_n[i]),
                .rd_lanes(rx_peek[i]),
                .level   (rx_level[i])
            );

            wfp_ep_counter #(
                .SIZE_W (SIZE_W),
                .IS_CTRL(i == 0)
            ) u_cnt (
                .clk     (clk),
                .rst     (rst),
                .load_tx (op.wr && hit && (op.sel == SEL_TXSZ)),
                .load_rx (op.wr && hit && (op.sel == SEL_RXSZ)),
                .load_val(host_wdata[SIZE_W-1:0]),
                .load_dir(host_wdata[SIZE_W]),
                .take_tx (tx_wr_n[i]),
                .take_rx (rx_rd_n[i]),
                .fault   (fault_hit && hit),
                .tx_rem  (tx_rem[i]),
                .rx_rem  (rx_rem[i]),
                .dir     (dir_vec[i]),
                .err     (ep_err[i])
            );

            assign usb_tx_empty[i] = (tx_level[i] == '0);
            assign usb_rx_full[i]  = (int'(rx_level[i]) == FIFO_DEPTH);
        end
    endgenerate

    assign usb_tx_byte = tx_head[usb_tx_ep];

    // Read data selection
    logic [31:0] rd_word;
    always_comb begin
        rd_word = '0;
        if (ep_ok) begin
            case (op.sel)
                SEL_DATA: if (rx_go) rd_word = pad_word(rx_peek[acc_ep], n_rx);
                SEL_TXSZ: begin
                    rd_word[SIZE_W-1:0] = (is_ctrl_acc && !dir_vec[acc_ep]) ? sel_rx_rem : sel_tx_rem;
                    rd_word[SIZE_W]     = dir_vec[acc_ep];
                end
                SEL_RXSZ: if (!is_ctrl_acc) rd_word[SIZE_W-1:0] = sel_rx_rem;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            host_rvalid <= op.rd;
            if (op.rd) host_rdata <= rd_word;
        end
    end

    assert_rvalid_follows_R6: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !host_wr) |=> host_rvalid);
    assert_write_wins_R12: assert property (@(posedge clk) disable iff (rst)
        host_wr |=> !host_rvalid);
    assert_pad_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (host_rvalid && $past(rx_go) && ($past(n_rx) == 3'd1)) |-> (host_rdata[31:8] == 24'h0));
    assert_err_on_empty_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_data_hit && (sel_tx_rem == '0)) |=> ep_err[$past(acc_ep)]);
    assert_fault_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_data_hit && !rx_go) |=> (host_rdata == 32'h0));

endmodule

// File: tb/wfp_word_port_test.sv
module wfp_word_port_test;
    localparam int NUM_EP     = 4;
    localparam int FIFO_DEPTH = 16;
    localparam int SIZE_W     = 16;
    localparam int EP_W       = 2;
    localparam int ADDR_W     = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              host_wr = 1'b0;
    logic              host_rd = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [31:0]       host_wdata = '0;
    logic [31:0]       host_rdata;
    logic              host_rvalid;
    logic              usb_tx_pop = 1'b0;
    logic [EP_W-1:0]   usb_tx_ep = '0;
    logic [7:0]        usb_tx_byte;
    logic [NUM_EP-1:0] usb_tx_empty;
    logic              usb_rx_push = 1'b0;
    logic [EP_W-1:0]   usb_rx_ep = '0;
    logic [7:0]        usb_rx_byte = '0;
    logic [NUM_EP-1:0] usb_rx_full;
    logic [NUM_EP-1:0] ep_err;

    wfp_word_port #(.NUM_EP(NUM_EP), .FIFO_DEPTH(FIFO_DEPTH), .SIZE_W(SIZE_W)) uut (
        .clk(clk), .rst(rst),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .usb_tx_pop(usb_tx_pop), .usb_tx_ep(usb_tx_ep), .usb_tx_byte(usb_tx_byte),
        .usb_tx_empty(usb_tx_empty),
        .usb_rx_push(usb_rx_push), .usb_rx_ep(usb_rx_ep), .usb_rx_byte(usb_rx_byte),
        .usb_rx_full(usb_rx_full), .ep_err(ep_err)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] data;
        string       tag;
    } exp_t;
    exp_t rq[$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] ad(input int ep, input int sel);
        return {2'(ep), 2'(sel)};
    endfunction

    // Monitor: compare read data against the scoreboard queue.
    always @(negedge clk) begin
        if (!rst && host_rvalid) begin
            if (rq.size() == 0) begin
                check(1'b0, "R12 stray read data", host_rdata, 32'h0);
            end else begin
                exp_t e;
                e = rq.pop_front();
                check(host_rdata === e.data, e.tag, host_rdata, e.data);
            end
        end
    end

    task automatic host_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        exp_t e;
        e.data = exp; e.tag = tag;
        rq.push_back(e);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic usb_push(input int ep, input logic [7:0] b);
        usb_rx_push = 1'b1; usb_rx_ep = 2'(ep); usb_rx_byte = b;
        @(negedge clk);
        usb_rx_push = 1'b0;
    endtask

    task automatic usb_pop_expect(input int ep, input logic [7:0] exp, input string tag);
        usb_tx_ep = 2'(ep);
        #1;
        check(!usb_tx_empty[ep] && usb_tx_byte === exp, tag, {24'h0, usb_tx_byte}, {24'h0, exp});
        usb_tx_pop = 1'b1;
        @(negedge clk);
        usb_tx_pop = 1'b0;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(usb_tx_empty === 4'hF, "R1 tx empty", {28'h0, usb_tx_empty}, 32'hF);
        check(usb_rx_full === 4'h0, "R1 rx full", {28'h0, usb_rx_full}, 32'h0);
        check(ep_err === 4'h0, "R1 err", {28'h0, ep_err}, 32'h0);
        check(host_rvalid === 1'b0, "R1 rvalid", {31'h0, host_rvalid}, 32'h0);
        host_read(ad(1, 1), 32'h0, "R1 tx count");

        // R4 / R5: six bytes on endpoint 1
        host_write(ad(1, 1), 32'd6);
        host_write(ad(1, 0), 32'h44332211);
        host_write(ad(1, 0), 32'hBBAA9988);
        usb_pop_expect(1, 8'h11, "R4 lane0");
        usb_pop_expect(1, 8'h22, "R4 lane1");
        usb_pop_expect(1, 8'h33, "R4 lane2");
        usb_pop_expect(1, 8'h44, "R4 lane3");
        usb_pop_expect(1, 8'h88, "R5 tail lane0");
        usb_pop_expect(1, 8'h99, "R5 tail lane1");
        check(usb_tx_empty[1] === 1'b1, "R5 upper lanes discarded", {31'h0, usb_tx_empty[1]}, 32'h1);
        host_read(ad(1, 1), 32'h0, "R2 tx count drained");
        check(ep_err[1] === 1'b0, "R4 no error", {31'h0, ep_err[1]}, 32'h0);

        // R8: write with zero count
        host_write(ad(1, 0), 32'h12345678);
        check(ep_err[1] === 1'b1, "R8 err set", {31'h0, ep_err[1]}, 32'h1);
        check(usb_tx_empty[1] === 1'b1, "R8 nothing pushed", {31'h0, usb_tx_empty[1]}, 32'h1);
        @(negedge clk);
        check(ep_err[1] === 1'b1, "R10 sticky", {31'h0, ep_err[1]}, 32'h1);
        host_write(ad(1, 2), 32'd0);
        check(ep_err[1] === 1'b0, "R10 cleared by size write", {31'h0, ep_err[1]}, 32'h0);

        // R6 / R7: seven receive bytes on endpoint 2
        for (int k = 1; k <= 7; k++) usb_push(2, 8'(k));
        host_write(ad(2, 2), 32'd7);
        host_read(ad(2, 0), 32'h04030201, "R6 full word");
        host_read(ad(2, 2), 32'd3, "R2 rx count");
        host_read(ad(2, 0), 32'h00070605, "R7 padded tail");
        check(ep_err[2] === 1'b0, "R6 no error", {31'h0, ep_err[2]}, 32'h0);

        // R3: control endpoint direction
        host_write(ad(0, 1), 32'h00010003);
        host_read(ad(0, 1), 32'h00010003, "R3 config readback");
        host_read(ad(0, 0), 32'h0, "R3 read in transmit direction");
        check(ep_err[0] === 1'b1, "R3 wrong direction err", {31'h0, ep_err[0]}, 32'h1);
        host_write(ad(0, 0), 32'hDDCCBBAA);
        usb_pop_expect(0, 8'hAA, "R5 ctrl lane0");
        usb_pop_expect(0, 8'hBB, "R5 ctrl lane1");
        usb_pop_expect(0, 8'hCC, "R5 ctrl lane2");
        check(usb_tx_empty[0] === 1'b1, "R5 ctrl lane3 dropped", {31'h0, usb_tx_empty[0]}, 32'h1);
        host_read(ad(0, 1), 32'h00010000, "R3 config drained");
        host_write(ad(0, 1), 32'h00000002);
        check(ep_err[0] === 1'b0, "R10 ctrl cleared", {31'h0, ep_err[0]}, 32'h0);
        usb_push(0, 8'h5A);
        usb_push(0, 8'hA5);
        host_write(ad(0, 0), 32'hFFFFFFFF);
        check(ep_err[0] === 1'b1 && usb_tx_empty[0] === 1'b1, "R3 write in receive direction",
              {30'h0, ep_err[0], usb_tx_empty[0]}, 32'h3);
        host_read(ad(0, 0), 32'h0000A55A, "R3 ctrl receive");

        // R9: short receive FIFO, full transmit FIFO on endpoint 3
        host_write(ad(3, 2), 32'd4);
        usb_push(3, 8'h01);
        usb_push(3, 8'h02);
        host_read(ad(3, 0), 32'h0, "R9 short rx returns zero");
        check(ep_err[3] === 1'b1, "R9 short rx err", {31'h0, ep_err[3]}, 32'h1);
        host_read(ad(3, 2), 32'd4, "R9 rx count kept");
        host_write(ad(3, 1), 32'd100);
        for (int k = 0; k < 4; k++) host_write(ad(3, 0), {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
        check(ep_err[3] === 1'b0, "R9 fill no err", {31'h0, ep_err[3]}, 32'h0);
        host_write(ad(3, 0), 32'hEEEEEEEE);
        check(ep_err[3] === 1'b1, "R9 no room err", {31'h0, ep_err[3]}, 32'h1);
        host_read(ad(3, 1), 32'd84, "R9 tx count kept");
        usb_pop_expect(3, 8'h00, "R9 data intact");

        // R11: pop on empty, push on full
        usb_tx_ep = 2'd1; usb_tx_pop = 1'b1;
        @(negedge clk);
        usb_tx_pop = 1'b0;
        check(usb_tx_empty[1] === 1'b1, "R11 pop on empty", {31'h0, usb_tx_empty[1]}, 32'h1);
        for (int k = 0; k < FIFO_DEPTH; k++) usb_push(1, 8'(8'h10 + k));
        check(usb_rx_full[1] === 1'b1, "R11 rx full", {31'h0, usb_rx_full[1]}, 32'h1);
        usb_push(1, 8'hEE);
        host_write(ad(1, 2), 32'd20);
        host_read(ad(1, 0), 32'h13121110, "R11 drain 0");
        host_read(ad(1, 0), 32'h17161514, "R11 drain 1");
        host_read(ad(1, 0), 32'h1B1A1918, "R11 drain 2");
        host_read(ad(1, 0), 32'h1F1E1D1C, "R11 drain 3");
        host_read(ad(1, 0), 32'h0, "R11 extra byte not stored");
        check(ep_err[1] === 1'b1, "R11 drained fifo err", {31'h0, ep_err[1]}, 32'h1);

        // R12: simultaneous write and read
        host_write(ad(1, 1), 32'd4);
        host_wr = 1'b1; host_rd = 1'b1; host_addr = ad(1, 0); host_wdata = 32'h000000C3;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        check(host_rvalid === 1'b0, "R12 no read data", {31'h0, host_rvalid}, 32'h0);
        usb_pop_expect(1, 8'hC3, "R12 write performed");

        // R2 reserved window
        host_read(ad(2, 3), 32'h0, "R2 reserved window");

        repeat (2) @(negedge clk);
        check(rq.size() == 0, "R6 all reads answered", 32'(rq.size()), 32'h0);
        done = 1'b1;
        report();
    end

endmodule